// File: doc/BRIEF.md
# Indirect Per-Channel Configuration Access Port

This block lets a host reach a per-channel configuration memory through a small register window instead of mapping every word into the address space. The host loads a 16-bit staging value into the data register, then writes the select register with a channel number, a word index and a direction flag. The select write starts a multi-cycle access and raises a busy flag in the select register. When the access finishes, the block either stores the staged value into memory or fills the data register with the stored word, and then drops busy. Software polls busy before it issues the next request.

The memory holds 40 channels of four 16-bit words each. It is single-ported and has no reset, so its contents survive both the hardware reset and the master clear. Bit 0 of a channel word is that channel's enable. Software sets it by reading the word, OR-ing in bit 0 and writing the word back.

A master clear bit in the control register resets the block's registers for as long as it stays set. Software must write it back to 0 before it can use the port again.

Top module: `cfg_ind_port`

## Requirements
- R1: After reset, every register address (0 control, 1 data, 2 select, 3 unused) reads 0.
- R2: A bus write to address 1 while the port is idle loads the data register, and address 1 reads back the stored value.
- R3: A bus write to address 2 while the port is idle starts an access, and bit 15 of the select register reads 1 from the next cycle on. The fields of the written word are: channel in bits 5..0, word index in bits 9..8, and direction in bit 14 (1 reads the word into the data register, 0 writes the data register into the word).
- R4: An access to a valid channel holds busy for exactly 3 cycles. When busy falls, a write access has stored the data register into the selected word, and a read access has loaded that word into the data register.
- R5: While bit 0 of the control register (address 0) is 1, the data and select registers and busy read 0 and bus writes to them are ignored. An access in flight is abandoned without touching memory. Memory contents are kept.
- R6: Each channel/word pair is a separate location. A read-modify-write that sets bit 0 (the channel enable) changes only that word.
- R7: While busy is 1, writes to the select register and to the data register are ignored. They start no second access and change no field.
- R8: A channel number of 40 to 63 holds busy for one cycle only and performs no memory access. The data register is left unchanged.
- R9: The select register reads back as: busy in bit 15, direction in bit 14, word index in bits 9..8, channel in bits 5..0. All other bits read 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus cycle valid |
| bus_we | input | 1 | 1 = write cycle |
| bus_addr | input | 2 | Register address (0 control, 1 data, 2 select) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |

## Verification
The bench goes after a second select issued one cycle into a busy window. A design that accepts it would start a second access and corrupt a neighbouring word. It also writes the data register during busy: a design that lets that through would store the late value instead of the staged one. Out-of-range channels are checked because an address that wraps could silently overwrite a real channel, and a long busy would show up as a stretched poll. A master clear raised mid-access must leave memory intact, which catches a design that lets the pending write land. The busy window is sampled cycle by cycle to catch an off-by-one in the access latency.

// File: rtl/cfg_ind_pkg.sv
package cfg_ind_pkg;

  localparam int DW       = 16;
  localparam int CH_W     = 6;
  localparam int BUSY_BIT = 15;
  localparam int RD_BIT   = 14;
  localparam int WSEL_LSB = 8;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_DATA = 2'd1,
    RA_SEL  = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  // Flat memory index of a channel/word pair.
  function automatic int unsigned cell_index(input int unsigned ch,
                                             input int unsigned w,
                                             input int unsigned n_word);
    return ch * n_word + w;
  endfunction

  // Read-back image of the select register.
  function automatic logic [DW-1:0] sel_image(input logic busy, input logic rd,
                                              input logic [3:0] w,
                                              input logic [CH_W-1:0] ch);
    logic [DW-1:0] img;
    img           = '0;
    img[BUSY_BIT] = busy;
    img[RD_BIT]   = rd;
    img[11:8]     = w;
    img[5:0]      = ch;
    return img;
  endfunction

endpackage

// File: rtl/cfg_ind_regs.sv
module cfg_ind_regs
  import cfg_ind_pkg::*;
#(
  parameter int WSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              busy,
  input  logic              sel_rd,
  input  logic [CH_W-1:0]   sel_ch,
  input  logic [WSEL_W-1:0] sel_word,
  input  logic              ld_en,
  input  logic [DW-1:0]     ld_data,
  output logic              mrst_q,
  output logic [DW-1:0]     data_q,
  output logic              sel_wr,
  output logic [CH_W-1:0]   new_ch,
  output logic [WSEL_W-1:0] new_word,
  output logic              new_rd,
  output logic [DW-1:0]     bus_rdata
);

  reg_addr_e ra;
  logic      wr;

  assign ra       = reg_addr_e'(bus_addr);
  assign wr       = bus_en & bus_we;
  assign sel_wr   = wr & (ra == RA_SEL) & ~mrst_q;
  assign new_ch   = bus_wdata[CH_W-1:0];
  assign new_word = bus_wdata[WSEL_LSB +: WSEL_W];
  assign new_rd   = bus_wdata[RD_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mrst_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (wr && ra == RA_CTRL) mrst_q <= bus_wdata[0];
      if (mrst_q)                            data_q <= '0;
      else if (ld_en)                        data_q <= ld_data;
      else if (wr && ra == RA_DATA && !busy) data_q <= bus_wdata;
    end
  end

  always_comb begin
    case (ra)
      RA_CTRL: bus_rdata = {{(DW-1){1'b0}}, mrst_q};
      RA_DATA: bus_rdata = data_q;
      RA_SEL:  bus_rdata = sel_image(busy, sel_rd, 4'(sel_word), sel_ch);
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/cfg_ind_seq.sv
module cfg_ind_seq
  import cfg_ind_pkg::*;
#(
  parameter int N_CH   = 40,
  parameter int N_WORD = 4,
  parameter int LAT    = 3,
  localparam int WSEL_W = $clog2(N_WORD),
  localparam int DEPTH  = N_CH * N_WORD,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrst,
  input  logic              sel_wr,
  input  logic [CH_W-1:0]   new_ch,
  input  logic [WSEL_W-1:0] new_word,
  input  logic              new_rd,
  output logic              busy,
  output logic [CH_W-1:0]   sel_ch,
  output logic [WSEL_W-1:0] sel_word,
  output logic              sel_rd,
  output logic              acc_fire,
  output logic              ram_we,
  output logic              ld_en,
  output logic [AW-1:0]     ram_addr
);

  localparam int CNT_W = $clog2(LAT + 1);

  logic             bad_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;
  logic             new_bad;

  assign accept  = sel_wr & ~busy;
  assign new_bad = int'(new_ch) >= N_CH;

  always_ff @(posedge clk) begin
    if (!rst_n || mrst) begin
      busy     <= 1'b0;
      bad_q    <= 1'b0;
      cnt_q    <= '0;
      sel_ch   <= '0;
      sel_word <= '0;
      sel_rd   <= 1'b0;
    end else if (accept) begin
      busy     <= 1'b1;
      bad_q    <= new_bad;
      cnt_q    <= new_bad ? '0 : CNT_W'(LAT - 1);
      sel_ch   <= new_ch;
      sel_word <= new_word;
      sel_rd   <= new_rd;
    end else if (busy) begin
      if (cnt_q == '0) busy  <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // The access lands on the last busy cycle, unless a master clear or a bad channel stops it.
  assign acc_fire = busy & (cnt_q == '0) & ~bad_q & ~mrst;
  assign ram_we   = acc_fire & ~sel_rd;
  assign ld_en    = acc_fire & sel_rd;
  assign ram_addr = AW'(cell_index(int'(sel_ch), int'(sel_word), N_WORD));

endmodule

// File: rtl/cfg_ind_ram.sv
module cfg_ind_ram #(
  parameter int DEPTH = 160,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/cfg_ind_port.sv
module cfg_ind_port
  import cfg_ind_pkg::*;
#(
  parameter int N_CH   = 40,
  parameter int N_WORD = 4,
  parameter int LAT    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata
);

  localparam int WSEL_W = $clog2(N_WORD);
  localparam int DEPTH  = N_CH * N_WORD;
  localparam int AW     = $clog2(DEPTH);

  logic              mrst_q;
  logic [DW-1:0]     data_q;
  logic              sel_wr;
  logic [CH_W-1:0]   new_ch;
  logic [WSEL_W-1:0] new_word;
  logic              new_rd;
  logic              busy;
  logic [CH_W-1:0]   sel_ch;
  logic [WSEL_W-1:0] sel_word;
  logic              sel_rd;
  logic              acc_fire;
  logic              ram_we;
  logic              ld_en;
  logic [AW-1:0]     ram_addr;
  logic [DW-1:0]     ram_rdata;

  cfg_ind_regs #(.WSEL_W(WSEL_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy),
    .sel_rd(sel_rd), .sel_ch(sel_ch), .sel_word(sel_word),
    .ld_en(ld_en), .ld_data(ram_rdata), .mrst_q(mrst_q), .data_q(data_q),
    .sel_wr(sel_wr), .new_ch(new_ch), .new_word(new_word), .new_rd(new_rd),
    .bus_rdata(bus_rdata)
  );

  cfg_ind_seq #(.N_CH(N_CH), .N_WORD(N_WORD), .LAT(LAT)) seq_i (
    .clk(clk), .rst_n(rst_n), .mrst(mrst_q), .sel_wr(sel_wr),
    .new_ch(new_ch), .new_word(new_word), .new_rd(new_rd),
    .busy(busy), .sel_ch(sel_ch), .sel_word(sel_word), .sel_rd(sel_rd),
    .acc_fire(acc_fire), .ram_we(ram_we), .ld_en(ld_en), .ram_addr(ram_addr)
  );

  cfg_ind_ram #(.DEPTH(DEPTH), .DW(DW)) ram_i (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(data_q), .rdata(ram_rdata)
  );

endmodule

// File: rtl/cfg_ind_port_chk.sv
module cfg_ind_port_chk #(
  parameter int N_CH = 40,
  parameter int LAT  = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mrst_q,
  input logic        busy,
  input logic        sel_wr,
  input logic        ram_we,
  input logic        ld_en,
  input logic [5:0]  sel_ch,
  input logic [5:0]  new_ch,
  input logic [15:0] data_q
);

  int run;

  always_ff @(posedge clk) begin
    if (!rst_n)    run <= 0;
    else if (busy) run <= run + 1;
    else           run <= 0;
  end

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && !busy |=> busy); // R3

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(mrst_q) && int'(sel_ch) < N_CH |-> run == LAT); // R4

  AST_READ_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> !busy); // R4

  AST_CLEAR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mrst_q |=> !busy && data_q == 16'h0000); // R5

  AST_SEL_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && busy |=> $stable(sel_ch)); // R7

  AST_BAD_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && !busy && int'(new_ch) >= N_CH |=> busy ##1 !busy); // R8

  AST_BAD_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && int'(sel_ch) >= N_CH |-> !ram_we && !ld_en); // R8

endmodule

bind cfg_ind_port cfg_ind_port_chk #(.N_CH(N_CH), .LAT(LAT)) chk_i (
  .clk(clk), .rst_n(rst_n), .mrst_q(mrst_q), .busy(busy), .sel_wr(sel_wr),
  .ram_we(ram_we), .ld_en(ld_en), .sel_ch(sel_ch), .new_ch(new_ch),
  .data_q(data_q)
);

// File: tb/cfg_ind_port_tb_top.sv
module cfg_ind_port_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;

  always #5 clk = ~clk;

  cfg_ind_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  string phase   = "R1";

  // Behavioural reference model
  logic [15:0] mmem [int];
  logic        m_mrst, m_rd, m_bad, was_busy;
  logic [15:0] m_data;
  logic [5:0]  m_ch;
  int          m_word, m_left, idx;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mrst = 0; m_data = 0; m_ch = 0; m_word = 0; m_rd = 0; m_bad = 0; m_left = 0;
    end else begin
      was_busy = (m_left > 0);
      if (m_mrst) begin
        m_data = 0; m_ch = 0; m_word = 0; m_rd = 0; m_bad = 0; m_left = 0;
      end else begin
        if (was_busy) begin
          m_left = m_left - 1;
          if (m_left == 0 && !m_bad) begin
            idx = m_ch * 4 + m_word;
            if (m_rd) m_data = mmem[idx];
            else      mmem[idx] = m_data;
          end
        end
        if (bus_en && bus_we && !was_busy) begin
          if (bus_addr == 2'd1) m_data = bus_wdata;
          if (bus_addr == 2'd2) begin
            m_ch   = bus_wdata[5:0];
            m_word = bus_wdata[9:8];
            m_rd   = bus_wdata[14];
            m_bad  = (m_ch >= 40);
            m_left = m_bad ? 1 : 3;
          end
        end
      end
      if (bus_en && bus_we && bus_addr == 2'd0) m_mrst = bus_wdata[0];
    end
  end

  function automatic logic [15:0] m_expect(input logic [1:0] a);
    case (a)
      2'd0: return {15'd0, m_mrst};
      2'd1: return m_data;
      2'd2: return 16'((int'(m_left > 0) << 15) | (int'(m_rd) << 14) |
                       (m_word << 8) | int'(m_ch));
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] fv(input int ch, input int w);
    return 16'((ch << 10) | (w << 8) | 8'h3C);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: compare against the model, drive, advance to the next falling edge.
  task automatic cyc(input logic en, input logic we, input logic [1:0] a, input logic [15:0] d);
    if (rst_n) check(phase, bus_rdata, m_expect(bus_addr));
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    cyc(1'b1, 1'b1, a, d);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    cyc(1'b0, 1'b0, a, 16'h0);
    v = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    int guard = 0;
    do begin
      rd(2'd2, v);
      guard++;
    end while (v[15] && guard < 50);
  endtask

  function automatic logic [15:0] sel_word_of(input int ch, input int w, input logic r);
    return 16'((int'(r) << 14) | (w << 8) | ch);
  endfunction

  task automatic do_write(input int ch, input int w, input logic [15:0] d);
    wr(2'd1, d);
    wr(2'd2, sel_word_of(ch, w, 1'b0));
    wait_idle();
  endtask

  task automatic do_read(input int ch, input int w, output logic [15:0] v);
    wr(2'd2, sel_word_of(ch, w, 1'b1));
    wait_idle();
    rd(2'd1, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    phase = "R1";
    rd(2'd0, v); check("R1 ctrl", v, 16'h0000);
    rd(2'd1, v); check("R1 data", v, 16'h0000);
    rd(2'd2, v); check("R1 sel", v, 16'h0000);
    rd(2'd3, v); check("R1 unused", v, 16'h0000);

    // R2: data register write/read
    phase = "R2";
    wr(2'd1, 16'hA5C3);
    rd(2'd1, v); check("R2 data readback", v, 16'hA5C3);

    // R3/R4: busy window of one write access, sampled per cycle
    phase = "R4";
    wr(2'd1, 16'h1234);
    wr(2'd2, sel_word_of(0, 0, 1'b0));
    check("R3 busy after select", bus_rdata[15] ? 16'h1 : 16'h0, 16'h1);
    rd(2'd2, v); check("R4 busy cycle 2", 16'(v[15]), 16'h1);
    rd(2'd2, v); check("R4 busy cycle 3", 16'(v[15]), 16'h1);
    rd(2'd2, v); check("R4 idle after 3", 16'(v[15]), 16'h0);

    // R4: fill every location, read some back
    for (int c = 0; c < 40; c++)
      for (int w = 0; w < 4; w++)
        do_write(c, w, fv(c, w));
    do_read(7, 2, v);  check("R4 read ch7 w2", v, fv(7, 2));
    do_read(39, 3, v); check("R4 read ch39 w3", v, fv(39, 3));
    do_read(0, 0, v);  check("R4 read ch0 w0", v, fv(0, 0));

    // R6: read-modify-write of the enable bit
    phase = "R6";
    do_read(1, 2, v);
    do_write(1, 2, v | 16'h0001);
    do_read(1, 2, v); check("R6 enable set", v, fv(1, 2) | 16'h0001);
    do_read(1, 1, v); check("R6 neighbour word", v, fv(1, 1));
    do_read(2, 2, v); check("R6 neighbour channel", v, fv(2, 2));

    // R7: select and data writes during busy are ignored
    phase = "R7";
    wr(2'd1, 16'h1111);
    wr(2'd2, sel_word_of(3, 1, 1'b0));
    wr(2'd2, sel_word_of(4, 0, 1'b0));
    wr(2'd1, 16'h2222);
    wait_idle();
    rd(2'd1, v); check("R7 data held", v, 16'h1111);
    do_read(3, 1, v); check("R7 first target", v, 16'h1111);
    do_read(4, 0, v); check("R7 second untouched", v, fv(4, 0));

    // R8: out-of-range channel
    phase = "R8";
    wr(2'd1, 16'h0F0F);
    wr(2'd2, sel_word_of(45, 1, 1'b1));
    check("R8 busy set", 16'(bus_rdata[15]), 16'h1);
    rd(2'd2, v); check("R8 busy one cycle", 16'(v[15]), 16'h0);
    rd(2'd1, v); check("R8 data unchanged", v, 16'h0F0F);
    wr(2'd2, sel_word_of(63, 3, 1'b0));
    wait_idle();
    do_read(39, 3, v); check("R8 no aliased write", v, fv(39, 3));

    // R9: select read-back layout with junk bits
    phase = "R9";
    wr(2'd2, 16'h7CD5);
    check("R9 image busy", bus_rdata, 16'hC015);
    wait_idle();
    rd(2'd2, v); check("R9 image idle", v, 16'h4015);

    // R5: master clear during an access
    phase = "R5";
    wr(2'd1, 16'hBEEF);
    wr(2'd2, sel_word_of(5, 0, 1'b0));
    wr(2'd0, 16'h0001);
    rd(2'd2, v); check("R5 sel cleared", v, 16'h0000);
    rd(2'd1, v); check("R5 data cleared", v, 16'h0000);
    wr(2'd1, 16'h7777);
    rd(2'd1, v); check("R5 data write ignored", v, 16'h0000);
    wr(2'd2, sel_word_of(6, 1, 1'b1));
    rd(2'd2, v); check("R5 sel write ignored", v, 16'h0000);
    rd(2'd0, v); check("R5 ctrl reads 1", v, 16'h0001);
    wr(2'd0, 16'h0000);
    do_read(5, 0, v); check("R5 memory kept", v, fv(5, 0));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule